// File: doc/BRIEF.md
# Per-Key Release Debounce Engine

This block keeps a small state word for every scancode that a key-matrix scanner can visit. The word holds a "held" flag and a release countdown. Each visit is a two-step update: a read strobe loads the key's word into a holding register, and a write strobe stores the updated word back. On that write the block may report an event. A key press is reported on the first closure the block sees for that key. A key release is reported only after the key has been seen open on a programmable number of consecutive whole scans. Any closure during that countdown cancels it without producing an event.

Events come out as a one-cycle valid strobe with a byte. The low seven bits hold the scancode. The top bit holds the direction. The storage starts in an unknown state at power-up. Each key is treated as released with a zero count on its first visit after reset, so keys already held at reset come out as press events during the first scan.

Top module: `kdb_engine`

## Requirements
- R1: While reset is asserted, and until the first write strobe after reset, `evt_valid` is 0. On its first visit after reset, each key behaves as released with a zero count, whatever was stored before the reset.
- R2: `evt_valid` is high only in the single clock cycle that follows a clock edge where `wr_phase` was high. The write uses the word captured at the most recent `rd_phase` edge, together with the scancode present at that read. `rd_phase` and `wr_phase` are never high in the same cycle.
- R3: When a key that is released with a zero count is seen closed, it becomes held and a press event is emitted. The press event byte is {1'b0, scancode}.
- R4: When a held key is seen closed, it stays held and no event is emitted.
- R5: When a held key is seen open and `reload` is N>0, it becomes released with count N and no event is emitted.
- R6: When a key that is released with count c>0 is seen open, the count becomes c-1. A release event {1'b1, scancode} is emitted only when c-1 is 0. With reload N, the release event therefore comes on the (N+1)th consecutive open visit after the key was held.
- R7: When a key that is released with a nonzero count is seen closed, it becomes held and no event is emitted. A later opening restarts the full countdown.
- R8: When a key that is released with a zero count is seen open, it stays that way and no event is emitted.
- R9: When `reload` is 0 and a held key is seen open, a release event is emitted on that same visit and the key goes to released with a zero count.
- R10: State is kept separately for each scancode. A visit to one key never changes the events produced for another key.
- R11: The largest reload, 127, delays the release event to the 128th consecutive open visit and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scan_code | input | 7 | Scancode of the key being visited, sampled at the read strobe |
| key_closed | input | 1 | 1 when the visited key switch is closed, sampled at the write strobe |
| rd_phase | input | 1 | Read strobe: loads the key's stored word |
| wr_phase | input | 1 | Write strobe: stores the updated word and decides on an event |
| reload | input | 7 | Release debounce count in whole scans |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_byte | output | 8 | Bit 7: 1 for release, 0 for press. Bits 6:0: scancode |

## Verification
The bench builds the engine with its default parameters: 7-bit scancodes, a 7-bit countdown and clear-on-first-visit enabled. These defaults make the extreme codes 0 and 127 and the maximum reload of 127 reachable, so the full 128-visit release wait can be checked and shown not to wrap. With these widths the bench can also interleave several keys, to show that each key keeps its own state. It can also assert reset while a key is held, to show that the stale stored word is ignored and the key produces a fresh press event.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_DOWN = 2'd1,
      ACT_UP   = 2'd2
   } kdb_act_e;

   localparam logic DIR_DOWN = 1'b0;
   localparam logic DIR_UP   = 1'b1;
endpackage

// File: rtl/kdb_store.sv
module kdb_store #(
   parameter int ADDR_W         = 7,
   parameter int WORD_W         = 8,
   parameter bit CLEAR_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_word
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("kdb_store: ADDR_W out of range");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("kdb_store: WORD_W too small");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic              seen_rd;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
   end

   if (CLEAR_ON_FIRST) begin : g_seen_map
      logic [DEPTH-1:0] seen;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen <= '0;
         else if (wr_en) seen[wr_addr] <= 1'b1;
      end
      assign seen_rd = seen[rd_addr];
   end else begin : g_no_map
      assign seen_rd = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_word <= '0;
      else if (rd_en) rd_word <= seen_rd ? mem[rd_addr] : '0;
   end
endmodule

// File: rtl/kdb_update.sv
module kdb_update
   import kdb_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             held_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             closed_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             held_o,
   output logic [CNT_W-1:0] count_o,
   output kdb_act_e         act_o
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("kdb_update: CNT_W out of range");
   end

   logic [CNT_W-1:0] dec;
   assign dec = count_i - 1'b1;

   always_comb begin
      held_o  = 1'b0;
      count_o = '0;
      act_o   = ACT_NONE;
      if (closed_i) begin
         held_o = 1'b1;
         if (!held_i && count_i == '0) act_o = ACT_DOWN;
      end else if (held_i) begin
         if (reload_i == '0) act_o = ACT_UP;
         else count_o = reload_i;
      end else if (count_i != '0) begin
         count_o = dec;
         if (dec == '0) act_o = ACT_UP;
      end
   end
endmodule

// File: rtl/kdb_engine.sv
module kdb_engine
   import kdb_pkg::*;
#(
   parameter int CODE_W         = 7,
   parameter int CNT_W          = 7,
   parameter bit CLEAR_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] scan_code,
   input  logic              key_closed,
   input  logic              rd_phase,
   input  logic              wr_phase,
   input  logic [CNT_W-1:0]  reload,
   output logic              evt_valid,
   output logic [CODE_W:0]   evt_byte
);
   localparam int WORD_W = CNT_W + 1;

   logic [CODE_W-1:0] code_q;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_n;
   logic              held_n;
   logic [CNT_W-1:0]  count_n;
   kdb_act_e          act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else if (rd_phase) code_q <= scan_code;
   end

   kdb_store #(
      .ADDR_W(CODE_W), .WORD_W(WORD_W), .CLEAR_ON_FIRST(CLEAR_ON_FIRST)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_phase), .rd_addr(scan_code), .rd_word(word_q),
      .wr_en(wr_phase), .wr_addr(code_q), .wr_word(word_n)
   );

   kdb_update #(.CNT_W(CNT_W)) u_update (
      .held_i(word_q[WORD_W-1]), .count_i(word_q[CNT_W-1:0]),
      .closed_i(key_closed), .reload_i(reload),
      .held_o(held_n), .count_o(count_n), .act_o(act)
   );

   assign word_n = {held_n, count_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_byte  <= '0;
      end else begin
         evt_valid <= wr_phase && (act != ACT_NONE);
         if (wr_phase && act != ACT_NONE)
            evt_byte <= {(act == ACT_UP) ? DIR_UP : DIR_DOWN, code_q};
      end
   end

   // R2: strobes never overlap, event only after a write strobe
   a_r2_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_phase && wr_phase));
   a_r2_evt_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> $past(wr_phase));
   // R3: press events only for closed switches
   a_r3_down_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_byte[CODE_W]) |-> $past(key_closed));
   // R6: release events only for open switches
   a_r6_up_open: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_byte[CODE_W]) |-> !$past(key_closed));
   // R4: held key that stays closed is silent
   a_r4_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_phase && word_q[WORD_W-1] && key_closed) |=> !evt_valid);
   // R9: zero reload releases at once
   a_r9_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_phase && word_q[WORD_W-1] && !key_closed && reload == '0)
      |=> (evt_valid && evt_byte[CODE_W]));
endmodule

// File: tb/kdb_engine_test.sv
module kdb_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] scan_code = '0;
   logic       key_closed = 1'b0;
   logic       rd_phase = 1'b0;
   logic       wr_phase = 1'b0;
   logic [6:0] reload = '0;
   logic       evt_valid;
   logic [7:0] evt_byte;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kdb_engine uut (
      .clk(clk), .rst_n(rst_n), .scan_code(scan_code), .key_closed(key_closed),
      .rd_phase(rd_phase), .wr_phase(wr_phase), .reload(reload),
      .evt_valid(evt_valid), .evt_byte(evt_byte)
   );

   // {code, closed, reload, exp_valid, exp_byte}
   localparam logic [23:0] VEC [NV] = '{
      {7'd5,   1'b1, 7'd3, 1'b1, 8'h05},  // R3 first press, R1 fresh state
      {7'd5,   1'b1, 7'd3, 1'b0, 8'h00},  // R4 held and closed
      {7'd5,   1'b0, 7'd3, 1'b0, 8'h00},  // R5 countdown loaded with 3
      {7'd5,   1'b0, 7'd3, 1'b0, 8'h00},  // R6 3->2
      {7'd5,   1'b0, 7'd3, 1'b0, 8'h00},  // R6 2->1
      {7'd5,   1'b0, 7'd3, 1'b1, 8'h85},  // R6 1->0 release
      {7'd5,   1'b0, 7'd3, 1'b0, 8'h00},  // R8 idle open
      {7'd9,   1'b1, 7'd2, 1'b1, 8'h09},  // R3
      {7'd9,   1'b0, 7'd2, 1'b0, 8'h00},  // R5
      {7'd9,   1'b1, 7'd2, 1'b0, 8'h00},  // R7 bounce swallowed
      {7'd9,   1'b0, 7'd2, 1'b0, 8'h00},  // R7 countdown restarts at 2
      {7'd9,   1'b0, 7'd2, 1'b0, 8'h00},  // R7 2->1
      {7'd9,   1'b0, 7'd2, 1'b1, 8'h89},  // R7 release after full count
      {7'd127, 1'b1, 7'd0, 1'b1, 8'h7F},  // R3 top code
      {7'd127, 1'b0, 7'd0, 1'b1, 8'hFF},  // R9 zero reload
      {7'd0,   1'b1, 7'd1, 1'b1, 8'h00},  // R10 key 0 press
      {7'd1,   1'b1, 7'd1, 1'b1, 8'h01},  // R10 key 1 press
      {7'd0,   1'b0, 7'd1, 1'b0, 8'h00},  // R10 key 0 count 1
      {7'd1,   1'b1, 7'd1, 1'b0, 8'h00},  // R10 key 1 still held
      {7'd0,   1'b0, 7'd1, 1'b1, 8'h80}   // R10 key 0 release
   };

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
                  tag, act[8], act[7:0], exp[8], exp[7:0]);
      end
   endtask

   // one visit: read strobe, write strobe, then sample the event cycle
   task automatic visit(input logic [6:0] code, input logic closed, input logic [6:0] rl,
                        output logic [8:0] res);
      @(negedge clk);
      scan_code = code; key_closed = closed; reload = rl; rd_phase = 1'b1;
      @(negedge clk);
      rd_phase = 1'b0; wr_phase = 1'b1;
      @(negedge clk);
      wr_phase = 1'b0;
      res = {evt_valid, evt_valid ? evt_byte : 8'h00};
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [8:0] r;
      repeat (3) @(negedge clk);
      check("R1 reset idle", {evt_valid, 8'h00}, 9'h000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {evt_valid, 8'h00}, 9'h000);

      for (int i = 0; i < NV; i++) begin
         visit(VEC[i][23:17], VEC[i][16], VEC[i][15:9], r);
         check($sformatf("vector %0d", i), r, VEC[i][8:0]);
      end

      // R2: the event lasts one cycle
      visit(7'd20, 1'b1, 7'd4, r);
      check("R2 press seen", r, {1'b1, 8'h14});
      @(negedge clk);
      check("R2 single pulse", {evt_valid, 8'h00}, 9'h000);
      // R2: read strobe alone gives no event
      @(negedge clk); scan_code = 7'd21; key_closed = 1'b1; rd_phase = 1'b1;
      @(negedge clk); rd_phase = 1'b0;
      @(negedge clk);
      check("R2 read only", {evt_valid, 8'h00}, 9'h000);

      // R11: maximum reload
      visit(7'd50, 1'b1, 7'd127, r);
      check("R11 press", r, {1'b1, 8'h32});
      for (int k = 0; k < 127; k++) begin
         visit(7'd50, 1'b0, 7'd127, r);
         if (r[8]) check($sformatf("R11 early release at %0d", k), r, 9'h000);
      end
      visit(7'd50, 1'b0, 7'd127, r);
      check("R11 release on visit 128", r, {1'b1, 8'hB2});
      visit(7'd50, 1'b0, 7'd127, r);
      check("R11 no wrap", r, 9'h000);

      // R1: reset while held; stale word must be ignored
      visit(7'd33, 1'b1, 7'd5, r);
      check("R1 pre-reset press", r, {1'b1, 8'h21});
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 held in reset", {evt_valid, 8'h00}, 9'h000);
      rst_n = 1'b1;
      visit(7'd33, 1'b1, 7'd5, r);
      check("R1 press again after reset", r, {1'b1, 8'h21});
      visit(7'd33, 1'b0, 7'd0, r);
      check("R9 release after reset", r, {1'b1, 8'hA1});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule